// File: doc/BRIEF.md
# Load/Store Address and Data Formatter

This block is the formatting stage of a 32-bit big-endian load/store unit. It takes one request per handshake. A request carries a base register index and value, an index register value, a signed 16-bit displacement, an access size, a load/store select, an algebraic (sign-extend) select, an update select, the store data and the memory word for a load. From these it forms the effective address. For stores it steers the data onto byte lanes and raises byte enables. For loads it pulls the addressed bytes out of the memory word and widens them to 32 bits. It also says whether the base register should receive the address.

The computation is combinational and lands in one output register. The input side and the output side are valid/ready streams. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output holds its value and no new request is accepted. The request fields need to be valid only while `in_valid` is high.

Unaligned accesses are formatted, not rejected. Bytes that would fall past the end of the 32-bit word are dropped from this word's lanes, and a misalignment flag tells the next stage to sequence the rest.

Top module: `ldst_formatter`

## Requirements
- R1: In displacement form (`use_index`=0), `out_ea` equals the base operand plus the 16-bit `disp` sign-extended to 32 bits, with modulo 2^32 wrap.
- R2: In indexed form (`use_index`=1), `out_ea` equals the base operand plus `index_val`. `disp` is ignored.
- R3: When `base_idx` is 0, the base operand is the constant 0 and `base_val` has no effect, in both address forms.
- R4: The `size` code is 0 for byte, 1 for halfword, 2 for word and 3 for reserved. For a legal store, the access occupies address offsets off to off+n-1, where off = `out_ea[1:0]` and n is the byte count. `out_be[3-a]` is set for each occupied offset a below 4. The lane with bit 3 holds address offset 0. The most significant byte of the store data goes to the lowest occupied offset. Offsets of 4 and above are dropped. All other `out_wdata` bytes are zero. For loads, `out_be` and `out_wdata` are zero.
- R5: A legal non-algebraic load returns the n bytes starting at offset off of `mem_word`. Offset 0 is `mem_word[31:24]`. The byte at the lowest offset becomes the most significant byte of the result. Offsets of 4 and above read as zero. All bits above the n bytes are zero.
- R6: An algebraic halfword load returns the same halfword as R5 in bits 15:0, with bits 31:16 filled with copies of bit 15.
- R7: `out_illegal` is set when `size` is 3, or when a load has `algebraic`=1 with a byte or word size. An illegal request gives `out_be`=0, `out_wdata`=0, `out_ldata`=0, `out_misalign`=0 and `out_wb_base`=0. For stores, `algebraic` has no effect.
- R8: `out_wb_base` equals `update` for a legal request and is 0 for an illegal one.
- R9: `out_misalign` is set for a legal halfword access with `out_ea[0]`=1, or a legal word access with `out_ea[1:0]`≠0. It is clear for bytes and for aligned accesses.
- R10: A request accepted at a clock edge appears on the outputs with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, `in_ready`=0 and all outputs hold.
- R11: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| base_idx | input | 5 | Base register index; 0 selects constant zero |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents for indexed form |
| disp | input | 16 | Signed displacement |
| use_index | input | 1 | 1 = indexed form, 0 = displacement form |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| is_store | input | 1 | 1 = store, 0 = load |
| algebraic | input | 1 | Sign-extending load select |
| update | input | 1 | Write address back to base register |
| st_data | input | 32 | Store data, right-justified |
| mem_word | input | 32 | Memory word containing the load data |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts result |
| out_ea | output | 32 | Effective address |
| out_size | output | 2 | Registered size code |
| out_is_store | output | 1 | Registered store select |
| out_be | output | 4 | Store byte enables, bit 3 = offset 0 |
| out_wdata | output | 32 | Store data on byte lanes |
| out_ldata | output | 32 | Extended load result |
| out_misalign | output | 1 | Access not naturally aligned |
| out_illegal | output | 1 | Illegal size/extension combination |
| out_wb_base | output | 1 | Base register receives `out_ea` |

## Verification
The hardest case to reach from the ports is a held output under back-pressure while a new request is already waiting. Two things must both be shown: the first result does not change, and the waiting request is not taken early. The stimulus pulls `out_ready` low, issues one request, and on the next cycle presents a second request with a different address. It then checks for two cycles that `in_ready` stays low and the first address is still on the outputs. Finally it releases `out_ready` and checks that the second address appears exactly one edge later. Halfword accesses at offset 3, which spill past the word, are driven for both loads and stores to pin down the dropped-byte rule.

// File: rtl/ldst_fmt_pkg.sv
package ldst_fmt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  // Byte count of an access; the reserved code maps to a full word but is
  // always accompanied by a cleared enable.
  function automatic int size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/ldst_ea.sv
module ldst_ea #(
  parameter int DW     = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [DW-1:0]     base_val,
  input  logic [DW-1:0]     index_val,
  input  logic [DISP_W-1:0] disp,
  input  logic              use_index,
  output logic [DW-1:0]     ea
);
  localparam int EXT_W = DW - DISP_W;

  logic [DW-1:0] base_opnd;
  logic [DW-1:0] disp_ext;
  logic [DW-1:0] addend;

  // Register index zero reads as a literal zero operand.
  assign base_opnd = (base_idx == '0) ? '0 : base_val;
  assign disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign addend    = use_index ? index_val : disp_ext;
  assign ea        = base_opnd + addend;
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
  import ldst_fmt_pkg::*;
#(
  parameter int DW = 32
) (
  input  acc_size_e                     size,
  input  logic [$clog2(DW/8)-1:0]       off,
  input  logic [DW-1:0]                 data,
  input  logic                          en,
  output logic [DW/8-1:0]               be,
  output logic [DW-1:0]                 wdata
);
  localparam int LANES = DW / 8;

  // Returns {enable, byte} for one lane. Lane index j holds address offset
  // LANES-1-j; k is the position of that offset inside the access, with 0
  // being the most significant byte of the data.
  function automatic logic [8:0] lane_pick(int lane, int offv, int n,
                                           logic [DW-1:0] d, logic e);
    logic [8:0] r;
    int k;
    r = '0;
    k = (LANES - 1 - lane) - offv;
    if (e && k >= 0 && k < n) r = {1'b1, d[8*(n-1-k) +: 8]};
    return r;
  endfunction

  int nbytes;
  int offset_i;
  always_comb begin
    nbytes   = size_bytes(size);
    offset_i = int'(off);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign {be[j], wdata[8*j +: 8]} = lane_pick(j, offset_i, nbytes, data, en);
  end
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_fmt_pkg::*;
#(
  parameter int DW = 32
) (
  input  acc_size_e               size,
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic [DW-1:0]           mem_word,
  input  logic                    algebraic,
  input  logic                    en,
  output logic [DW-1:0]           ldata
);
  localparam int LANES = DW / 8;
  localparam int HW    = 16;

  logic [DW-1:0] raw;

  always_comb begin
    int n;
    int offv;
    n    = size_bytes(size);
    offv = int'(off);
    raw  = '0;
    // Access byte k sits at address offset offv+k; offsets past the word
    // are left zero for the next stage to fetch.
    for (int k = 0; k < LANES; k++) begin
      if (k < n && (offv + k) < LANES)
        raw[8*(n-1-k) +: 8] = mem_word[8*(LANES-1-offv-k) +: 8];
    end
    if (!en)
      ldata = '0;
    else if (algebraic && size == SZ_HALF)
      ldata = {{(DW-HW){raw[HW-1]}}, raw[HW-1:0]};
    else
      ldata = raw;
  end
endmodule

// File: rtl/ldst_formatter.sv
module ldst_formatter
  import ldst_fmt_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [DW-1:0]     base_val,
  input  logic [DW-1:0]     index_val,
  input  logic [DISP_W-1:0] disp,
  input  logic              use_index,
  input  logic [1:0]        size,
  input  logic              is_store,
  input  logic              algebraic,
  input  logic              update,
  input  logic [DW-1:0]     st_data,
  input  logic [DW-1:0]     mem_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_ea,
  output logic [1:0]        out_size,
  output logic              out_is_store,
  output logic [DW/8-1:0]   out_be,
  output logic [DW-1:0]     out_wdata,
  output logic [DW-1:0]     out_ldata,
  output logic              out_misalign,
  output logic              out_illegal,
  output logic              out_wb_base
);
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);

  acc_size_e           sz;
  logic [DW-1:0]       ea;
  logic [OFFW-1:0]     off;
  logic                illegal;
  logic                misalign;
  logic                st_en;
  logic                ld_en;
  logic [LANES-1:0]    be_c;
  logic [DW-1:0]       wdata_c;
  logic [DW-1:0]       ldata_c;

  assign sz  = acc_size_e'(size);
  assign off = ea[OFFW-1:0];

  ldst_ea #(.DW(DW), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_ea (
    .base_idx (base_idx),
    .base_val (base_val),
    .index_val(index_val),
    .disp     (disp),
    .use_index(use_index),
    .ea       (ea)
  );

  // Sign extension is legal for halfword loads only; the reserved size
  // code is never legal.
  assign illegal = (sz == SZ_BAD) || (!is_store && algebraic && sz != SZ_HALF);
  assign st_en   = is_store && !illegal;
  assign ld_en   = !is_store && !illegal;

  always_comb begin
    case (sz)
      SZ_HALF: misalign = ea[0];
      SZ_WORD: misalign = (off != '0);
      default: misalign = 1'b0;
    endcase
  end

  ldst_store_lanes #(.DW(DW)) u_st (
    .size (sz),
    .off  (off),
    .data (st_data),
    .en   (st_en),
    .be   (be_c),
    .wdata(wdata_c)
  );

  ldst_load_extract #(.DW(DW)) u_ld (
    .size     (sz),
    .off      (off),
    .mem_word (mem_word),
    .algebraic(algebraic),
    .en       (ld_en),
    .ldata    (ldata_c)
  );

  // Single output register with valid/ready; empty or draining accepts.
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_ea       <= '0;
      out_size     <= '0;
      out_is_store <= 1'b0;
      out_be       <= '0;
      out_wdata    <= '0;
      out_ldata    <= '0;
      out_misalign <= 1'b0;
      out_illegal  <= 1'b0;
      out_wb_base  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ea       <= ea;
        out_size     <= size;
        out_is_store <= is_store;
        out_be       <= be_c;
        out_wdata    <= wdata_c;
        out_ldata    <= ldata_c;
        out_misalign <= misalign && !illegal;
        out_illegal  <= illegal;
        out_wb_base  <= update && !illegal;
      end
    end
  end

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ea) && $stable(out_be)
                                 && $stable(out_ldata) && $stable(out_wdata));

  assert_no_accept_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_be == '0 && !out_wb_base && out_ldata == '0
                                 && !out_misalign);

  assert_word_misalign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal && out_size == 2'd2 && out_ea[1:0] != 2'd0
      |-> out_misalign);

  assert_byte_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_store && !out_illegal && out_size == 2'd0
      |-> out_ldata[DW-1:8] == '0);

  assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_store && !out_illegal && out_size == 2'd0
      |-> $countones(out_be) == 1);
endmodule

// File: tb/sim_ldst_formatter.sv
module sim_ldst_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  base_idx = '0;
  logic [31:0] base_val = '0;
  logic [31:0] index_val = '0;
  logic [15:0] disp = '0;
  logic        use_index = 1'b0;
  logic [1:0]  size = '0;
  logic        is_store = 1'b0;
  logic        algebraic = 1'b0;
  logic        update = 1'b0;
  logic [31:0] st_data = '0;
  logic [31:0] mem_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_ea;
  logic [1:0]  out_size;
  logic        out_is_store;
  logic [3:0]  out_be;
  logic [31:0] out_wdata;
  logic [31:0] out_ldata;
  logic        out_misalign;
  logic        out_illegal;
  logic        out_wb_base;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ldst_formatter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_idx(base_idx), .base_val(base_val), .index_val(index_val),
    .disp(disp), .use_index(use_index), .size(size), .is_store(is_store),
    .algebraic(algebraic), .update(update), .st_data(st_data),
    .mem_word(mem_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_ea(out_ea), .out_size(out_size), .out_is_store(out_is_store),
    .out_be(out_be), .out_wdata(out_wdata), .out_ldata(out_ldata),
    .out_misalign(out_misalign), .out_illegal(out_illegal),
    .out_wb_base(out_wb_base)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model from the requirements (shift formulation).
  function automatic logic [31:0] ref_ea();
    logic [31:0] b;
    b = (base_idx == 5'd0) ? 32'd0 : base_val;
    return b + (use_index ? index_val : {{16{disp[15]}}, disp});
  endfunction

  function automatic bit ref_illegal();
    return (size == 2'd3) || (!is_store && algebraic && size != 2'd1);
  endfunction

  function automatic int ref_n();
    return (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
  endfunction

  task automatic send(string tag);
    logic [31:0] e_ea, e_wd, e_ld, sh;
    logic [3:0]  e_be, top;
    bit          ill, mis;
    int          n, off;
    @(negedge clk);
    in_valid = 1'b1;
    e_ea = ref_ea();
    ill  = ref_illegal();
    n    = ref_n();
    off  = int'(e_ea[1:0]);
    top  = 4'b1111 << (4 - n);
    e_be = (is_store && !ill) ? (top >> off) : 4'd0;
    e_wd = (is_store && !ill) ? ((st_data << (32 - 8*n)) >> (8*off)) : 32'd0;
    sh   = mem_word << (8*off);
    if (is_store || ill) e_ld = 32'd0;
    else if (n == 1) e_ld = {24'd0, sh[31:24]};
    else if (n == 2) e_ld = algebraic ? {{16{sh[31]}}, sh[31:16]} : {16'd0, sh[31:16]};
    else e_ld = sh;
    mis = !ill && ((n == 2 && off[0]) || (n == 4 && off != 0));
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R10 valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " R1 R2 R3 ea"}, out_ea, e_ea);
    chk({tag, " R4 be"}, {28'd0, out_be}, {28'd0, e_be});
    chk({tag, " R4 wdata"}, out_wdata, e_wd);
    chk({tag, " R5 R6 ldata"}, out_ldata, e_ld);
    chk({tag, " R7 illegal"}, {31'd0, out_illegal}, {31'd0, ill});
    chk({tag, " R9 misalign"}, {31'd0, out_misalign}, {31'd0, mis});
    chk({tag, " R8 wb"}, {31'd0, out_wb_base}, {31'd0, update && !ill});
  endtask

  task automatic setup(logic st, logic [1:0] sz, logic alg, logic upd);
    is_store = st; size = sz; algebraic = alg; update = upd;
  endtask

  task automatic t_reset_r11();
    chk("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_ea_r1_r2_r3();
    setup(1'b0, 2'd2, 1'b0, 1'b0); mem_word = 32'h0;
    base_idx = 5'd3; base_val = 32'h0000_1000; use_index = 1'b0;
    disp = 16'hFFF0; send("R1 neg disp");
    disp = 16'h7FFC; send("R1 pos disp");
    base_val = 32'hFFFF_FFF8; disp = 16'h0010; send("R1 wrap");
    use_index = 1'b1; base_val = 32'h0000_2000; index_val = 32'h0000_0124;
    disp = 16'h8000; send("R2 indexed");
    base_idx = 5'd0; base_val = 32'hDEAD_0000; index_val = 32'h0000_0040;
    send("R3 r0 indexed");
    use_index = 1'b0; disp = 16'h0044; send("R3 r0 disp");
    base_idx = 5'd3;
  endtask

  task automatic t_store_r4();
    base_idx = 5'd1; use_index = 1'b0; disp = 16'h0;
    st_data = 32'hA1B2_C3D4;
    setup(1'b1, 2'd0, 1'b0, 1'b0); base_val = 32'h100; send("R4 byte off0");
    base_val = 32'h101; send("R4 byte off1");
    base_val = 32'h103; send("R4 byte off3");
    setup(1'b1, 2'd1, 1'b0, 1'b0); base_val = 32'h102; send("R4 half off2");
    base_val = 32'h103; send("R4 half off3 spill");
    setup(1'b1, 2'd2, 1'b0, 1'b0); base_val = 32'h100; send("R4 word off0");
    base_val = 32'h101; send("R4 word off1 spill");
    setup(1'b1, 2'd0, 1'b1, 1'b0); base_val = 32'h102; send("R7 alg store ignored");
  endtask

  task automatic t_load_r5_r6();
    base_idx = 5'd1; use_index = 1'b0; disp = 16'h0;
    mem_word = 32'h1182_83F4;
    setup(1'b0, 2'd0, 1'b0, 1'b0); base_val = 32'h202; send("R5 byte off2");
    base_val = 32'h203; send("R5 byte off3");
    setup(1'b0, 2'd1, 1'b0, 1'b0); base_val = 32'h200; send("R5 half off0");
    base_val = 32'h202; send("R5 half zext neg");
    setup(1'b0, 2'd2, 1'b0, 1'b0); base_val = 32'h200; send("R5 word off0");
    base_val = 32'h202; send("R5 word off2 spill");
    setup(1'b0, 2'd1, 1'b1, 1'b0); base_val = 32'h202; send("R6 alg half neg");
    base_val = 32'h200; send("R6 alg half pos");
    base_val = 32'h203; send("R6 alg half off3");
  endtask

  task automatic t_illegal_r7();
    base_idx = 5'd2; base_val = 32'h300; disp = 16'h1; use_index = 1'b0;
    mem_word = 32'h8899_AABB; st_data = 32'h1234_5678;
    setup(1'b0, 2'd0, 1'b1, 1'b1); send("R7 alg byte load");
    setup(1'b0, 2'd2, 1'b1, 1'b1); send("R7 alg word load");
    setup(1'b1, 2'd3, 1'b0, 1'b1); send("R7 reserved store");
    setup(1'b0, 2'd3, 1'b0, 1'b0); send("R7 reserved load");
  endtask

  task automatic t_update_misalign_r8_r9();
    base_idx = 5'd4; use_index = 1'b0; disp = 16'h0; mem_word = 32'h0102_0304;
    setup(1'b0, 2'd2, 1'b0, 1'b1); base_val = 32'h400; send("R8 update aligned word");
    setup(1'b1, 2'd1, 1'b0, 1'b1); base_val = 32'h401; send("R9 R8 half odd");
    setup(1'b0, 2'd2, 1'b0, 1'b0); base_val = 32'h402; send("R9 word off2");
    setup(1'b0, 2'd0, 1'b0, 1'b0); base_val = 32'h403; send("R9 byte never");
    chk("R8 explicit wb low", {31'd0, out_wb_base}, 32'd0);
    chk("R9 explicit byte clear", {31'd0, out_misalign}, 32'd0);
  endtask

  task automatic t_backpressure_r10();
    base_idx = 5'd5; use_index = 1'b0; setup(1'b0, 2'd2, 1'b0, 1'b0);
    @(negedge clk);
    out_ready = 1'b0; base_val = 32'h0000_5000; disp = 16'h0; in_valid = 1'b1;
    @(negedge clk);
    chk("R10 stall first valid", {31'd0, out_valid}, 32'd1);
    chk("R10 stall first ea", out_ea, 32'h0000_5000);
    base_val = 32'h0000_6000;
    chk("R10 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R10 hold ea", out_ea, 32'h0000_5000);
    chk("R10 in_ready still low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second accepted", out_ea, 32'h0000_6000);
    chk("R10 second valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r11();
    t_ea_r1_r2_r3();
    t_store_r4();
    t_load_r5_r6();
    t_illegal_r7();
    t_update_misalign_r8_r9();
    t_backpressure_r10();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule